// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between a host bus and a set of internal registers plus a data port that fronts a FIFO. The bus can work in one of two ways. In strobe mode, asynchronous read and write strobes drive each access and an active-high ready line stretches the cycle. In clocked mode, a cycle-start pulse opens each access and an active-low ready is returned for one clock.

The host first latches the address with the address strobe. The latched address is then decoded to a one-hot register select, to the data port, or to nothing. A separate data-port chip select skips the decoder and sends the access straight to the data port, which lets a DMA engine stream words without setting up addresses. Such an access has to use all four byte lanes.

Data-port traffic leaves the block as a valid/ready request. The request stays up, with its direction fixed, until the FIFO side accepts it. Until then the host sees not-ready in either mode. The local bus clock and the core clock are the same net, `clk`. Clocked-mode inputs are sampled on its rising edge.

Top module: `hbi_bridge`

## Requirements
- R1: The address register loads `addr_i` on every rising `clk` edge at which `ads_n` is low. It holds its value while `ads_n` is high, so the last address seen with `ads_n` low is the one used.
- R2: A latched address below NREG (8) that is not DP_ADDR (6) is a register access. Bit `a` of `reg_sel_o` is set, together with a one-clock `reg_rd_o` or `reg_wr_o`. Address DP_ADDR goes to the data port. Addresses of NREG or more complete with no pulse and no request. `reg_sel_o` is zero outside a pulse.
- R3: In strobe mode, `rd_n` and `wr_n` each pass through a two-flop synchronizer. The access is served in the clock after the third rising edge that follows a strobe's falling edge. A `wr_n` fall is a write and a `rd_n` fall is a read.
- R4: In strobe mode, `ardy_o` falls combinationally while `rd_n` or `wr_n` is low and the access is not finished. It rises two clocks after the serve clock and stays high until the strobe is released. In clocked mode, `ardy_o` stays high.
- R5: In clocked mode, `cyc_n` sampled low at a rising edge starts a cycle, which is served in the next clock. `wr_n` low at that edge means write, otherwise read. `srdy_n_o` is low for exactly the one clock after the serve clock. In strobe mode it stays high.
- R6: When `dcs_n` is low at the start of an access and `be_n` is 4'b0000 (all lanes), the access goes to the data port whatever the latched address.
- R7: When `dcs_n` is low and `be_n` is not 4'b0000, the access raises `dcs_err_o` for the serve clock only. It produces no register pulse and no data-port request, but it still completes with the normal ready timing.
- R8: `dp_valid_o` stays high with a stable `dp_write_o` until `dp_ready_i` is high. The serve clock is the handshake clock, and the host's ready is withheld until then.
- R9: The mode input `bus_sync_i` (1 = clocked) is taken only while the block is idle and all bus strobes are high. A change during an access affects only later accesses.
- R10: In clocked mode, `rd_n`/`wr_n` activity without `cyc_n` does nothing. In strobe mode, `cyc_n` does nothing.
- R11: In reset with strobes high, all pulses and `dp_valid_o` are low, `ardy_o` is high, `srdy_n_o` is high, and the block is in strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the local bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Host address |
| ads_n | input | 1 | Address strobe, latch open while low |
| rd_n | input | 1 | Read strobe (strobe mode) |
| wr_n | input | 1 | Write strobe (strobe mode), direction (clocked mode) |
| cyc_n | input | 1 | Cycle start (clocked mode) |
| bus_sync_i | input | 1 | Mode select: 1 clocked, 0 strobe |
| dcs_n | input | 1 | Data-port chip select, bypasses decoder |
| be_n | input | BEW | Active-low byte enables |
| reg_sel_o | output | NREG | One-hot register select |
| reg_rd_o | output | 1 | Register read pulse |
| reg_wr_o | output | 1 | Register write pulse |
| dp_valid_o | output | 1 | Data-port request valid |
| dp_write_o | output | 1 | Data-port request direction |
| dp_ready_i | input | 1 | FIFO can satisfy the request |
| dcs_err_o | output | 1 | Narrow bypass access flagged |
| ardy_o | output | 1 | Strobe-mode ready, low extends cycle |
| srdy_n_o | output | 1 | Clocked-mode ready, low for one clock |

## Verification
The hardest case to reach is a mode change that arrives in the middle of a strobe-mode access. The bench moves `bus_sync_i` to clocked right after the serve clock, while the strobe is still held low. It then checks that the release still follows strobe-mode timing and that `srdy_n_o` never falls. Only after the strobe is released does a clocked cycle succeed. Back-pressure is reached by holding `dp_ready_i` low for zero to three clocks in both modes and watching both ready outputs during the wait.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    TG_REG   = 2'd0,
    TG_DPORT = 2'd1,
    TG_NONE  = 2'd2,
    TG_BADW  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DONE  = 2'd3
  } st_e;
endpackage

// File: rtl/hbi_addr_dec.sv
module hbi_addr_dec
  import hbi_pkg::*;
#(
  parameter int AW      = 4,
  parameter int NREG    = 8,
  parameter int DP_ADDR = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            ads_n,
  output tgt_e            tgt_o,
  output logic [NREG-1:0] sel_o
);
  localparam logic [AW-1:0] DP_A   = AW'(DP_ADDR);
  localparam logic [AW:0]   NREG_W = (AW+1)'(NREG);

  logic [AW-1:0] addr_q;

  // clocked stand-in for a transparent latch: open while ads_n is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (!ads_n) addr_q <= addr_i;
  end

  always_comb begin
    if (addr_q == DP_A)                tgt_o = TG_DPORT;
    else if ({1'b0, addr_q} < NREG_W)  tgt_o = TG_REG;
    else                               tgt_o = TG_NONE;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = (tgt_o == TG_REG) && (addr_q == AW'(i));
  end
endmodule

// File: rtl/hbi_strobe_sync.sv
module hbi_strobe_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], in_n[i]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_n[i] = chain_q[STAGES-1];
    assign fall[i]  = prev_q & ~chain_q[STAGES-1];
  end
endmodule

// File: rtl/hbi_cycle_fsm.sv
module hbi_cycle_fsm
  import hbi_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int BEW      = 4,
  parameter int REL_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            cyc_n,
  input  logic            rd_raw_n,
  input  logic            wr_raw_n,
  input  logic            rd_lvl_n,
  input  logic            wr_lvl_n,
  input  logic            rd_fall,
  input  logic            wr_fall,
  input  logic            dcs_n,
  input  logic [BEW-1:0]  be_n,
  input  tgt_e            dec_tgt,
  input  logic [NREG-1:0] dec_sel,
  input  logic            dp_ready_i,
  output logic [NREG-1:0] reg_sel_o,
  output logic            reg_rd_o,
  output logic            reg_wr_o,
  output logic            dp_valid_o,
  output logic            dp_write_o,
  output logic            dcs_err_o,
  output logic            ardy_o,
  output logic            srdy_n_o
);
  localparam int            CW       = $clog2(REL_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(REL_CLKS - 1);

  st_e             st_q, st_d;
  tgt_e            tgt_q, tgt_new;
  logic            wr_q, wr_new;
  logic [NREG-1:0] sel_q;
  logic            sync_q;
  logic [CW-1:0]   cnt_q;
  logic            srdy_q;
  logic            start, served, quiet, in_serve;

  always_comb begin
    start   = sync_q ? !cyc_n : (rd_fall || wr_fall);
    tgt_new = !dcs_n ? ((be_n == '0) ? TG_DPORT : TG_BADW) : dec_tgt;
    wr_new  = sync_q ? !wr_raw_n : wr_fall;
    in_serve = (st_q == ST_SERVE);
    served  = in_serve && ((tgt_q != TG_DPORT) || dp_ready_i);
    quiet   = rd_raw_n && wr_raw_n && rd_lvl_n && wr_lvl_n && cyc_n;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_SERVE;
      ST_SERVE: if (served) st_d = sync_q ? ST_IDLE :
                                   ((REL_CLKS < 2) ? ST_DONE : ST_HOLD);
      ST_HOLD:  if (cnt_q >= CNT_LAST) st_d = ST_DONE;
      ST_DONE:  if (rd_lvl_n && wr_lvl_n) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= TG_NONE;
      wr_q   <= 1'b0;
      sel_q  <= '0;
      sync_q <= 1'b0;
      cnt_q  <= '0;
      srdy_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      srdy_q <= !(served && sync_q);
      if (st_q == ST_IDLE && start) begin
        tgt_q <= tgt_new;
        wr_q  <= wr_new;
        sel_q <= dec_sel;
      end
      if (st_q == ST_IDLE && !start && quiet) sync_q <= mode_i;
      if (st_d == ST_HOLD && st_q != ST_HOLD) cnt_q <= CW'(1);
      else if (st_q == ST_HOLD)               cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    reg_rd_o   = in_serve && (tgt_q == TG_REG) && !wr_q;
    reg_wr_o   = in_serve && (tgt_q == TG_REG) && wr_q;
    reg_sel_o  = (in_serve && (tgt_q == TG_REG)) ? sel_q : '0;
    dp_valid_o = in_serve && (tgt_q == TG_DPORT);
    dp_write_o = wr_q;
    dcs_err_o  = in_serve && (tgt_q == TG_BADW);
    ardy_o     = sync_q || (rd_raw_n && wr_raw_n) || (st_q == ST_DONE);
    srdy_n_o   = srdy_q;
  end
endmodule

// File: rtl/hbi_bridge.sv
module hbi_bridge
  import hbi_pkg::*;
#(
  parameter int AW       = 4,
  parameter int NREG     = 8,
  parameter int DP_ADDR  = 6,
  parameter int BEW      = 4,
  parameter int REL_CLKS = 2,
  parameter int STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            ads_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            cyc_n,
  input  logic            bus_sync_i,
  input  logic            dcs_n,
  input  logic [BEW-1:0]  be_n,
  output logic [NREG-1:0] reg_sel_o,
  output logic            reg_rd_o,
  output logic            reg_wr_o,
  output logic            dp_valid_o,
  output logic            dp_write_o,
  input  logic            dp_ready_i,
  output logic            dcs_err_o,
  output logic            ardy_o,
  output logic            srdy_n_o
);
  tgt_e            dec_tgt;
  logic [NREG-1:0] dec_sel;
  logic [1:0]      lvl_n, fall;

  hbi_addr_dec #(.AW(AW), .NREG(NREG), .DP_ADDR(DP_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ads_n(ads_n),
    .tgt_o(dec_tgt), .sel_o(dec_sel)
  );

  hbi_strobe_sync #(.N(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .in_n({wr_n, rd_n}),
    .lvl_n(lvl_n), .fall(fall)
  );

  hbi_cycle_fsm #(.NREG(NREG), .BEW(BEW), .REL_CLKS(REL_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_i(bus_sync_i), .cyc_n(cyc_n),
    .rd_raw_n(rd_n), .wr_raw_n(wr_n),
    .rd_lvl_n(lvl_n[0]), .wr_lvl_n(lvl_n[1]),
    .rd_fall(fall[0]), .wr_fall(fall[1]),
    .dcs_n(dcs_n), .be_n(be_n), .dec_tgt(dec_tgt), .dec_sel(dec_sel),
    .dp_ready_i(dp_ready_i),
    .reg_sel_o(reg_sel_o), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
    .dp_valid_o(dp_valid_o), .dp_write_o(dp_write_o),
    .dcs_err_o(dcs_err_o), .ardy_o(ardy_o), .srdy_n_o(srdy_n_o)
  );
endmodule

// File: rtl/hbi_bridge_chk.sv
module hbi_bridge_chk #(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic [NREG-1:0] reg_sel_o,
  input logic            reg_rd_o,
  input logic            reg_wr_o,
  input logic            dp_valid_o,
  input logic            dp_write_o,
  input logic            dp_ready_i,
  input logic            dcs_err_o,
  input logic            ardy_o,
  input logic            srdy_n_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o)); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o || reg_wr_o) |-> $countones(reg_sel_o) == 1); // R2
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o || reg_wr_o) |-> reg_sel_o == '0); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o || reg_wr_o) |=> !(reg_rd_o || reg_wr_o)); // R3
  AST_ARDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ardy_o |-> (!rd_n || !wr_n)); // R4
  AST_SRDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !srdy_n_o |=> srdy_n_o); // R5
  AST_SRDY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !srdy_n_o |-> ardy_o); // R5
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    dcs_err_o |-> !(dp_valid_o || reg_rd_o || reg_wr_o)); // R7
  AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid_o && !dp_ready_i) |=> (dp_valid_o && $stable(dp_write_o))); // R8
endmodule

bind hbi_bridge hbi_bridge_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
  .reg_sel_o(reg_sel_o), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
  .dp_valid_o(dp_valid_o), .dp_write_o(dp_write_o), .dp_ready_i(dp_ready_i),
  .dcs_err_o(dcs_err_o), .ardy_o(ardy_o), .srdy_n_o(srdy_n_o)
);

// File: tb/hbi_bridge_test.sv
module hbi_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, NREG = 8, DP = 6, BEW = 4;
  localparam int T_REG = 0, T_DP = 1, T_NONE = 2, T_ERR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic ads_n = 1, rd_n = 1, wr_n = 1, cyc_n = 1, bus_sync_i = 0, dcs_n = 1;
  logic [BEW-1:0] be_n = '0;
  logic dp_ready_i = 0;
  logic [NREG-1:0] reg_sel_o;
  logic reg_rd_o, reg_wr_o, dp_valid_o, dp_write_o, dcs_err_o, ardy_o, srdy_n_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbi_bridge #(.AW(AW), .NREG(NREG), .DP_ADDR(DP), .BEW(BEW)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tgt_of(int a, bit dcs, logic [BEW-1:0] be);
    if (dcs) return (be == '0) ? T_DP : T_ERR;
    if (a == DP) return T_DP;
    if (a < NREG) return T_REG;
    return T_NONE;
  endfunction

  task automatic expect_serve(input int tgt, input bit isw, input int a);
    chk("R2 R3 reg_rd_o", reg_rd_o, (tgt == T_REG) && !isw);
    chk("R2 R3 reg_wr_o", reg_wr_o, (tgt == T_REG) && isw);
    chk("R2 reg_sel_o", reg_sel_o, (tgt == T_REG) ? (32'd1 << a) : 32'd0);
    chk("R6 dp_valid_o", dp_valid_o, tgt == T_DP);
    if (tgt == T_DP) chk("R6 dp_write_o", dp_write_o, isw);
    chk("R7 dcs_err_o", dcs_err_o, tgt == T_ERR);
  endtask

  task automatic no_pulse(input string req);
    chk(req, {reg_rd_o, reg_wr_o, dp_valid_o, dcs_err_o}, 0);
  endtask

  task automatic latch_addr(input int a);
    @(negedge clk) addr_i = AW'(a); ads_n = 0;
    @(negedge clk) ads_n = 1; addr_i = ~AW'(a);
  endtask

  task automatic wait_dp(input int tgt, input int wc, input bit isw, input bit sync_m);
    if (tgt == T_DP && wc > 0) begin
      for (int i = 1; i < wc; i++) begin
        @(posedge clk); #1;
        chk("R8 dp_valid_o held", dp_valid_o, 1);
        chk("R8 dp_write_o stable", dp_write_o, isw);
        if (sync_m) chk("R8 srdy_n_o withheld", srdy_n_o, 1);
        else        chk("R8 ardy_o withheld", ardy_o, 0);
      end
      @(negedge clk) dp_ready_i = 1;
    end
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk) bus_sync_i = m;
    repeat (3) @(posedge clk);
  endtask

  task automatic async_acc(input int a, input bit isw, input bit dcs,
                           input logic [BEW-1:0] be, input int wc);
    int tgt = tgt_of(a, dcs, be);
    latch_addr(a);
    @(negedge clk) dcs_n = !dcs; be_n = be; dp_ready_i = (wc == 0);
    if (isw) wr_n = 0; else rd_n = 0;
    #1 chk("R4 ardy_o falls with strobe", ardy_o, 0);
    repeat (2) begin
      @(posedge clk); #1;
      no_pulse("R3 no early serve");
      chk("R4 ardy_o low", ardy_o, 0);
    end
    @(posedge clk); #1;
    expect_serve(tgt, isw, a);
    chk("R5 srdy_n_o idle in strobe mode", srdy_n_o, 1);
    wait_dp(tgt, wc, isw, 0);
    @(posedge clk); #1;
    no_pulse("R4 after serve");
    chk("R4 ardy_o serve+1", ardy_o, 0);
    @(posedge clk); #1;
    chk("R4 ardy_o serve+2", ardy_o, 1);
    @(negedge clk) rd_n = 1; wr_n = 1; dcs_n = 1; be_n = '0; dp_ready_i = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic sync_acc(input int a, input bit isw, input bit dcs,
                          input logic [BEW-1:0] be, input int wc);
    int tgt = tgt_of(a, dcs, be);
    latch_addr(a);
    @(negedge clk) cyc_n = 0; wr_n = !isw; dcs_n = !dcs; be_n = be; dp_ready_i = (wc == 0);
    @(posedge clk); #1;
    expect_serve(tgt, isw, a);
    chk("R5 srdy_n_o high in serve", srdy_n_o, 1);
    chk("R4 ardy_o high in clocked mode", ardy_o, 1);
    @(negedge clk) cyc_n = 1;
    wait_dp(tgt, wc, isw, 1);
    @(posedge clk); #1;
    chk("R5 srdy_n_o low after serve", srdy_n_o, 0);
    no_pulse("R5 after serve");
    @(posedge clk); #1;
    chk("R5 srdy_n_o one clock", srdy_n_o, 1);
    @(negedge clk) wr_n = 1; dcs_n = 1; be_n = '0; dp_ready_i = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk); #1;
    // R11 reset state
    no_pulse("R11 pulses in reset");
    chk("R11 ardy_o in reset", ardy_o, 1);
    chk("R11 srdy_n_o in reset", srdy_n_o, 1);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);

    // R1 R2 R3 R4 full address and direction sweep, strobe mode
    for (int a = 0; a < 16; a++)
      for (int w = 0; w < 2; w++) async_acc(a, w[0], 0, '0, 0);

    // R1 last address while ads_n low wins
    @(negedge clk) addr_i = 3; ads_n = 0;
    @(negedge clk) addr_i = 5;
    @(negedge clk) ads_n = 1; addr_i = 0;
    @(negedge clk) rd_n = 0;
    repeat (3) @(posedge clk); #1;
    chk("R1 latched address selects reg 5", reg_sel_o, 32'h20);
    repeat (2) @(posedge clk);
    @(negedge clk) rd_n = 1;
    repeat (4) @(posedge clk);

    // R6 R7 byte-enable sweep on the bypass path, strobe mode
    for (int b = 0; b < 16; b++) async_acc(b, b[0], 1, BEW'(b), 0);
    // R8 back-pressure, strobe mode
    for (int wc = 0; wc < 4; wc++) async_acc(DP, wc[0], 0, '0, wc);
    async_acc(2, 1, 1, '0, 3);

    // R10 cyc_n ignored in strobe mode
    @(negedge clk) cyc_n = 0;
    @(negedge clk) cyc_n = 1;
    repeat (4) begin
      @(posedge clk); #1;
      no_pulse("R10 cyc_n ignored in strobe mode");
      chk("R10 srdy_n_o stays high", srdy_n_o, 1);
    end

    // R9 mode change during a strobe access
    latch_addr(1);
    @(negedge clk) rd_n = 0;
    repeat (3) @(posedge clk); #1;
    expect_serve(T_REG, 0, 1);
    @(negedge clk) bus_sync_i = 1;
    @(posedge clk); #1;
    chk("R9 ardy_o still strobe timing", ardy_o, 0);
    chk("R9 srdy_n_o untouched", srdy_n_o, 1);
    @(posedge clk); #1;
    chk("R9 ardy_o released serve+2", ardy_o, 1);
    chk("R9 srdy_n_o untouched", srdy_n_o, 1);
    @(negedge clk) rd_n = 1;
    repeat (5) @(posedge clk);

    // R5 R2 sweep, clocked mode (mode taken once idle)
    for (int a = 0; a < 16; a++)
      for (int w = 0; w < 2; w++) sync_acc(a, w[0], 0, '0, 0);
    for (int b = 0; b < 16; b++) sync_acc(b, b[1], 1, BEW'(b), 0);
    for (int wc = 0; wc < 4; wc++) sync_acc(DP, wc[0], 0, '0, wc);
    sync_acc(9, 0, 1, '0, 2);

    // R10 strobes ignored in clocked mode
    @(negedge clk) rd_n = 0;
    repeat (5) begin
      @(posedge clk); #1;
      no_pulse("R10 rd_n ignored in clocked mode");
      chk("R10 ardy_o high", ardy_o, 1);
    end
    @(negedge clk) rd_n = 1;
    repeat (4) @(posedge clk);

    // R9 back to strobe mode only after idle
    set_mode(0);
    async_acc(4, 1, 0, '0, 0);

    finished = 1;
    finish_run();
  end
endmodule